// File: doc/BRIEF.md
# Protection Controller Configuration Register File

This block is the 32-bit memory-mapped register file of a memory protection controller. Software uses it to program a security lookup table that holds one bit per memory block, and to set the controller options: whether a blocked access gets a bus error, whether the table window steps its index by itself, and a lockdown that freezes the setup until reset. The table is reached through an index register and a data window. Each read or write of the window goes to the table word the index selects. The whole table is driven out in parallel to the access filter, which sits in another block.

Accesses come in on a simple request bus. Each request carries a word-aligned offset, a size, lane-aligned write data and a secure flag. Read data returns on the cycle after the request, with a valid strobe. The interrupt registers are decoded here, but their state belongs to the interrupt block. This block only returns the values that block supplies and sends it registered write pulses. Non-secure requests can see only the identification words at the top of the map.

Top module: `prot_cfg_regs`

## Requirements
- R1: After reset, control reads 0x100 (auto-increment on, error response off, not locked), the index reads 0, every table bit is 0 and every interrupt pulse output is low.
- R2: Control keeps only bit 4 (error response, driven on `errRespEn`), bit 8 (auto-increment) and bit 31 (lockdown). Every other control bit reads 0 whatever was written.
- R3: A write to the index (offset 0x18) stores the merged value modulo TBL_WORDS. Offset 0x10 reads TBL_WORDS.
- R4: Reads and writes of the window (offset 0x1C) reach table word `index`. Table word k drives `lutBits[32k+31:32k]`.
- R5: With auto-increment on, every word-size (busSize 2 or 3) read, and every accepted write, of the window advances the index by one and wraps from TBL_WORDS-1 to 0. Byte and halfword accesses never advance it, and nothing advances it while auto-increment is off.
- R6: While lockdown is set, writes to control, to the window and to interrupt enable (0x28) have no effect. A refused window write does not advance the index. Lockdown stays set until reset.
- R7: A non-secure request (busSecure=0) to an offset below 0xFD0 reads 0 and its write has no effect.
- R8: busSize 0 is a byte, 1 a halfword and 2 or 3 a word, on lanes picked by busAddr[1:0]. A narrow write to control, index or window merges into the current value. For any other register the lanes not written count as zero. Reads always return the whole word.
- R9: Writes with bit 0 set pulse `intClrPulse` (offset 0x24) or `intSetPulse` (offset 0x34) for one cycle. A write to 0x28 pulses `intEnWrite` with `intEnData` equal to bit 0. Offsets 0x20, 0x28, 0x2C and 0x30 read `intStatIn`, `intEnIn`, `intInfo1In` and `intInfo2In`.
- R10: Offset 0xFD0+4k (k from 0 to 11) reads byte k of ID_BYTES, zero-extended. Writes to read-only offsets are ignored. Write-only and unmapped offsets read 0. No request raises an error.
- R11: The read result appears on `busRdata`, with `busRvalid` high, on the cycle after the read request. Interrupt pulses come out on that same cycle after the write.
- R12: Offset 0x14 reads the BLK_CFG parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Request valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset in the register window |
| busSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| busWdata | input | 32 | Lane-aligned write data |
| busSecure | input | 1 | Request is secure |
| busRdata | output | 32 | Read data, one cycle after the request |
| busRvalid | output | 1 | busRdata is valid |
| errRespEn | output | 1 | Blocked accesses get a bus error |
| lutBits | output | TBL_WORDS*32 | Whole security table, one bit per block |
| intStatIn | input | 1 | Interrupt status from the interrupt block |
| intEnIn | input | 1 | Interrupt enable from the interrupt block |
| intInfo1In | input | 32 | First capture word from the interrupt block |
| intInfo2In | input | 32 | Second capture word from the interrupt block |
| intEnWrite | output | 1 | Pulse: interrupt enable written |
| intEnData | output | 1 | New interrupt enable value |
| intClrPulse | output | 1 | Pulse: clear interrupt |
| intSetPulse | output | 1 | Pulse: set interrupt |

## Verification
A word access to the window reads or updates a table word and advances the index in the same clock edge. Read data must therefore come from the entry the index held before it advanced, and the next access must land on the following entry. Back-to-back word reads and writes to 0x1C are issued across the wrap point and mixed with narrow accesses and auto-increment toggles. Each returned word and the parallel table image are compared with a bench model that applies the access first and the advance second. Lockdown collides with the same path: a refused window write must leave both the table and the index as they were.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_MAX   = 12'h010;
  localparam logic [11:0] OFS_CFG   = 12'h014;
  localparam logic [11:0] OFS_IDX   = 12'h018;
  localparam logic [11:0] OFS_LUT   = 12'h01C;
  localparam logic [11:0] OFS_ISTAT = 12'h020;
  localparam logic [11:0] OFS_ICLR  = 12'h024;
  localparam logic [11:0] OFS_IEN   = 12'h028;
  localparam logic [11:0] OFS_INFO1 = 12'h02C;
  localparam logic [11:0] OFS_INFO2 = 12'h030;
  localparam logic [11:0] OFS_ISET  = 12'h034;
  localparam logic [11:0] OFS_IDLO  = 12'hFD0;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_CTRL, SEL_MAX, SEL_CFG, SEL_IDX, SEL_LUT,
    SEL_ISTAT, SEL_IEN, SEL_INFO1, SEL_INFO2, SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic       wrCtrl;
    logic       wrIdx;
    logic       wrLut;
    logic       wrIntEn;
    logic       wrClr;
    logic       wrSet;
    logic       stepIdx;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [3:0] laneMask;
    logic [3:0] idSlot;
  } strobe_t;

endpackage

// File: rtl/prot_cfg_decode.sv
module prot_cfg_decode
  import prot_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [1:0]  busSize,
  input  logic        busSecure,
  input  logic        lockState,
  input  logic        autoIncOn,
  output strobe_t     st
);

  logic [11:0] offset;
  logic [11:0] slotOfs;
  logic        nsBlocked;
  logic        isWord;
  logic        go;
  rdSel_e      hitSel;

  always_comb begin
    offset    = {busAddr[11:2], 2'b00};
    nsBlocked = !busSecure && (offset < OFS_IDLO);
    isWord    = busSize[1];
    go        = busSel && busWrite && !nsBlocked;
    slotOfs   = offset - OFS_IDLO;
    hitSel    = SEL_ZERO;
    case (offset)
      OFS_CTRL:  hitSel = SEL_CTRL;
      OFS_MAX:   hitSel = SEL_MAX;
      OFS_CFG:   hitSel = SEL_CFG;
      OFS_IDX:   hitSel = SEL_IDX;
      OFS_LUT:   hitSel = SEL_LUT;
      OFS_ISTAT: hitSel = SEL_ISTAT;
      OFS_IEN:   hitSel = SEL_IEN;
      OFS_INFO1: hitSel = SEL_INFO1;
      OFS_INFO2: hitSel = SEL_INFO2;
      default:   if (offset >= OFS_IDLO) hitSel = SEL_ID;
    endcase
  end

  always_comb begin
    st = '0;
    case (busSize)
      2'd0:    st.laneMask = 4'b0001 << busAddr[1:0];
      2'd1:    st.laneMask = busAddr[1] ? 4'b1100 : 4'b0011;
      default: st.laneMask = 4'b1111;
    endcase
    st.idSlot  = (hitSel == SEL_ID) ? slotOfs[5:2] : 4'd0;
    st.wrCtrl  = go && (hitSel == SEL_CTRL) && !lockState;
    st.wrIdx   = go && (hitSel == SEL_IDX);
    st.wrLut   = go && (hitSel == SEL_LUT) && !lockState;
    st.wrIntEn = go && (hitSel == SEL_IEN) && !lockState;
    st.wrClr   = go && (offset == OFS_ICLR);
    st.wrSet   = go && (offset == OFS_ISET);
    st.stepIdx = busSel && !nsBlocked && (hitSel == SEL_LUT) && isWord &&
                 autoIncOn && (!busWrite || !lockState);
    st.rdEn    = busSel && !busWrite;
    st.rdSel   = nsBlocked ? SEL_ZERO : hitSel;
  end

  // R7: a non-secure request below the identification range produces no update
  p_ns_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busSecure && busAddr < OFS_IDLO) |->
      !(st.wrCtrl || st.wrIdx || st.wrLut || st.wrIntEn || st.wrClr ||
        st.wrSet || st.stepIdx));

  // R6: lockdown refuses control, window and enable writes
  p_lock_guard_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockState |-> !(st.wrCtrl || st.wrLut || st.wrIntEn));

endmodule

// File: rtl/prot_cfg_datapath.sv
module prot_cfg_datapath
  import prot_cfg_pkg::*;
#(
  parameter int          TBL_WORDS = 5,
  parameter int          IDX_W     = 3,
  parameter int          BLK_CFG   = 7,
  parameter logic [95:0] ID_BYTES  = 96'h0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                st,
  input  logic [31:0]            busWdata,
  input  logic                   intStatIn,
  input  logic                   intEnIn,
  input  logic [31:0]            intInfo1In,
  input  logic [31:0]            intInfo2In,
  output logic [31:0]            busRdata,
  output logic                   busRvalid,
  output logic                   lockState,
  output logic                   autoIncOn,
  output logic                   errRespEn,
  output logic [TBL_WORDS*32-1:0] lutBits,
  output logic                   intEnWrite,
  output logic                   intEnData,
  output logic                   intClrPulse,
  output logic                   intSetPulse
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_WORDS - 1);

  logic [TBL_WORDS*32-1:0] lutFlat;
  logic [TBL_WORDS-1:0]    wordHit;
  logic [IDX_W-1:0]        idxReg;
  logic [31:0]             byteMask;
  logic [31:0]             wMasked;
  logic [31:0]             ctrlWord;
  logic [31:0]             ctrlNext;
  logic [31:0]             idxMerged;
  logic [31:0]             idxWrapped;
  logic [31:0]             lutCur;
  logic [31:0]             lutNext;
  logic [95:0]             idShift;
  logic [31:0]             rdMux;

  assign byteMask = {{8{st.laneMask[3]}}, {8{st.laneMask[2]}},
                     {8{st.laneMask[1]}}, {8{st.laneMask[0]}}};
  assign wMasked  = busWdata & byteMask;
  assign ctrlWord = {lockState, 22'b0, autoIncOn, 3'b0, errRespEn, 4'b0};
  assign ctrlNext = (ctrlWord & ~byteMask) | wMasked;
  assign idxMerged  = ({{(32-IDX_W){1'b0}}, idxReg} & ~byteMask) | wMasked;
  assign idxWrapped = idxMerged % 32'(TBL_WORDS);

  always_comb begin
    lutCur = '0;
    for (int k = 0; k < TBL_WORDS; k++)
      if (idxReg == IDX_W'(k)) lutCur = lutFlat[32*k +: 32];
  end
  assign lutNext = (lutCur & ~byteMask) | wMasked;

  genvar g;
  generate
    for (g = 0; g < TBL_WORDS; g++) begin : gWordHit
      assign wordHit[g] = st.wrLut && (idxReg == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lutFlat <= '0;
    end else begin
      for (int k = 0; k < TBL_WORDS; k++)
        if (wordHit[k]) lutFlat[32*k +: 32] <= lutNext;
    end
  end
  assign lutBits = lutFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errRespEn <= 1'b0;
      autoIncOn <= 1'b1;
      lockState <= 1'b0;
      idxReg    <= '0;
    end else begin
      if (st.wrCtrl) begin
        errRespEn <= ctrlNext[4];
        autoIncOn <= ctrlNext[8];
        lockState <= ctrlNext[31];
      end
      if (st.wrIdx)        idxReg <= idxWrapped[IDX_W-1:0];
      else if (st.stepIdx) idxReg <= (idxReg == LAST_IDX) ? '0 : idxReg + 1'b1;
    end
  end

  assign idShift = ID_BYTES >> {st.idSlot, 3'b000};

  always_comb begin
    case (st.rdSel)
      SEL_CTRL:  rdMux = ctrlWord;
      SEL_MAX:   rdMux = 32'(TBL_WORDS);
      SEL_CFG:   rdMux = 32'(BLK_CFG);
      SEL_IDX:   rdMux = {{(32-IDX_W){1'b0}}, idxReg};
      SEL_LUT:   rdMux = lutCur;
      SEL_ISTAT: rdMux = {31'b0, intStatIn};
      SEL_IEN:   rdMux = {31'b0, intEnIn};
      SEL_INFO1: rdMux = intInfo1In;
      SEL_INFO2: rdMux = intInfo2In;
      SEL_ID:    rdMux = {24'b0, idShift[7:0]};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata    <= '0;
      busRvalid   <= 1'b0;
      intEnWrite  <= 1'b0;
      intEnData   <= 1'b0;
      intClrPulse <= 1'b0;
      intSetPulse <= 1'b0;
    end else begin
      busRvalid   <= st.rdEn;
      if (st.rdEn) busRdata <= rdMux;
      intEnWrite  <= st.wrIntEn;
      intEnData   <= st.wrIntEn && wMasked[0];
      intClrPulse <= st.wrClr && wMasked[0];
      intSetPulse <= st.wrSet && wMasked[0];
    end
  end

  // R3: the index never leaves the table
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, idxReg} < (IDX_W+1)'(TBL_WORDS));

  // R5: stepping from the last word lands on word zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepIdx && idxReg == LAST_IDX) |=> (idxReg == '0));

  // R6: lockdown is sticky and freezes control
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> lockState);
  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> $stable(ctrlWord));

  // R11: a read request is answered on the next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.rdEn |=> busRvalid);

endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_cfg_pkg::*;
#(
  parameter int          TBL_WORDS = 5,
  parameter int          BLK_CFG   = 7,
  parameter logic [95:0] ID_BYTES  = 96'h0D_72_A4_3C_00_01_5E_91_00_00_00_07
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busSel,
  input  logic                    busWrite,
  input  logic [11:0]             busAddr,
  input  logic [1:0]              busSize,
  input  logic [31:0]             busWdata,
  input  logic                    busSecure,
  output logic [31:0]             busRdata,
  output logic                    busRvalid,
  output logic                    errRespEn,
  output logic [TBL_WORDS*32-1:0] lutBits,
  input  logic                    intStatIn,
  input  logic                    intEnIn,
  input  logic [31:0]             intInfo1In,
  input  logic [31:0]             intInfo2In,
  output logic                    intEnWrite,
  output logic                    intEnData,
  output logic                    intClrPulse,
  output logic                    intSetPulse
);

  localparam int IDX_W = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1;

  strobe_t st;
  logic    lockState;
  logic    autoIncOn;

  prot_cfg_decode u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busSecure (busSecure),
    .lockState (lockState),
    .autoIncOn (autoIncOn),
    .st        (st)
  );

  prot_cfg_datapath #(
    .TBL_WORDS (TBL_WORDS),
    .IDX_W     (IDX_W),
    .BLK_CFG   (BLK_CFG),
    .ID_BYTES  (ID_BYTES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .busWdata    (busWdata),
    .intStatIn   (intStatIn),
    .intEnIn     (intEnIn),
    .intInfo1In  (intInfo1In),
    .intInfo2In  (intInfo2In),
    .busRdata    (busRdata),
    .busRvalid   (busRvalid),
    .lockState   (lockState),
    .autoIncOn   (autoIncOn),
    .errRespEn   (errRespEn),
    .lutBits     (lutBits),
    .intEnWrite  (intEnWrite),
    .intEnData   (intEnData),
    .intClrPulse (intClrPulse),
    .intSetPulse (intSetPulse)
  );

endmodule

// File: tb/prot_cfg_regs_bench.sv
module prot_cfg_regs_bench;

  localparam int          TW  = 5;
  localparam int          BC  = 7;
  localparam logic [95:0] IDV = 96'h0D_72_A4_3C_00_01_5E_91_00_00_00_07;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rstN, busSel, busWrite, busSecure;
  logic [11:0]     busAddr;
  logic [1:0]      busSize;
  logic [31:0]     busWdata, busRdata, intInfo1In, intInfo2In;
  logic            busRvalid, errRespEn, intStatIn, intEnIn;
  logic [TW*32-1:0] lutBits;
  logic            intEnWrite, intEnData, intClrPulse, intSetPulse;

  prot_cfg_regs #(.TBL_WORDS(TW), .BLK_CFG(BC), .ID_BYTES(IDV)) u_prot_cfg_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busSecure(busSecure), .busRdata(busRdata), .busRvalid(busRvalid),
    .errRespEn(errRespEn), .lutBits(lutBits), .intStatIn(intStatIn),
    .intEnIn(intEnIn), .intInfo1In(intInfo1In), .intInfo2In(intInfo2In),
    .intEnWrite(intEnWrite), .intEnData(intEnData),
    .intClrPulse(intClrPulse), .intSetPulse(intSetPulse));

  int total = 0;
  int bad   = 0;
  logic [31:0] mLut [TW];
  logic mSec, mAuto, mLock;
  int   mIdx;

  function automatic logic [31:0] laneMask(logic [1:0] a, logic [1:0] sz);
    logic [31:0] m;
    case (sz)
      2'd0:    m = 32'hFF << (8 * a);
      2'd1:    m = a[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] ctrlVal();
    return {mLock, 22'b0, mAuto, 3'b0, mSec, 4'b0};
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] off, logic sec);
    logic [95:0] sh;
    if (!sec && off < 12'hFD0) return 32'h0;
    if (off >= 12'hFD0) begin
      sh = IDV >> (8 * ((off - 12'hFD0) >> 2));
      return {24'b0, sh[7:0]};
    end
    case (off)
      12'h000: return ctrlVal();
      12'h010: return 32'(TW);
      12'h014: return 32'(BC);
      12'h018: return 32'(mIdx);
      12'h01C: return mLut[mIdx];
      12'h020: return {31'b0, intStatIn};
      12'h028: return {31'b0, intEnIn};
      12'h02C: return intInfo1In;
      12'h030: return intInfo2In;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(logic [11:0] off, logic sec);
    if (!sec && off < 12'hFD0) return "R7";
    if (off >= 12'hFD0) return "R10";
    case (off)
      12'h000: return "R2";
      12'h010, 12'h018: return "R3";
      12'h014: return "R12";
      12'h01C: return "R4";
      12'h020, 12'h028, 12'h02C, 12'h030: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < TW; k++) mLut[k] = '0;
    mSec = 0; mAuto = 1; mLock = 0; mIdx = 0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 0; busSel = 0; busWrite = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(lutBits == '0, "R1", "table after reset", lutBits[31:0], 32'h0);
    check({intEnWrite, intClrPulse, intSetPulse, errRespEn} == 4'b0, "R1",
          "pulses after reset", {28'b0, intEnWrite, intClrPulse, intSetPulse, errRespEn}, 32'h0);
  endtask

  task automatic access(bit wr, logic [11:0] addr, logic [1:0] sz,
                        logic [31:0] wd, logic sec);
    logic [11:0] off;
    logic [31:0] m, v, expR, mw;
    bit blocked, eEn, eEnD, eClr, eSet;
    logic [TW*32-1:0] expLut;
    off = {addr[11:2], 2'b00};
    blocked = !sec && off < 12'hFD0;
    m  = laneMask(addr[1:0], sz);
    mw = wd & m;
    expR = expRead(off, sec);
    eEn = 0; eEnD = 0; eClr = 0; eSet = 0;
    if (!blocked) begin
      if (wr) begin
        case (off)
          12'h000: if (!mLock) begin
            v = (ctrlVal() & ~m) | mw;
            mSec = v[4]; mAuto = v[8]; mLock = v[31];
          end
          12'h018: begin
            v = (32'(mIdx) & ~m) | mw;
            mIdx = int'(v % 32'(TW));
          end
          12'h01C: if (!mLock) begin
            mLut[mIdx] = (mLut[mIdx] & ~m) | mw;
            if (sz[1] && mAuto) mIdx = (mIdx + 1) % TW;
          end
          12'h024: eClr = mw[0];
          12'h034: eSet = mw[0];
          12'h028: if (!mLock) begin eEn = 1; eEnD = mw[0]; end
          default: ;
        endcase
      end else if (off == 12'h01C && sz[1] && mAuto) begin
        mIdx = (mIdx + 1) % TW;
      end
    end
    @(negedge clk);
    busSel = 1; busWrite = wr; busAddr = addr; busSize = sz;
    busWdata = wd; busSecure = sec;
    @(negedge clk);
    busSel = 0; busWrite = 0;
    if (!wr) begin
      check(busRvalid, "R11", "read valid", {31'b0, busRvalid}, 32'h1);
      check(busRdata == expR, tagFor(off, sec), $sformatf("read @%h", addr), busRdata, expR);
    end else begin
      check({intEnWrite, intEnData, intClrPulse, intSetPulse} ==
            {eEn, eEnD, eClr, eSet}, (blocked ? "R7" : (mLock ? "R6" : "R9")),
            $sformatf("pulses @%h", addr),
            {28'b0, intEnWrite, intEnData, intClrPulse, intSetPulse},
            {28'b0, eEn, eEnD, eClr, eSet});
    end
    for (int k = 0; k < TW; k++) expLut[32*k +: 32] = mLut[k];
    check(lutBits == expLut, "R4", "table image", lutBits[31:0], expLut[31:0]);
    check(errRespEn == mSec, "R2", "error response out", {31'b0, errRespEn}, {31'b0, mSec});
  endtask

  task automatic readIdx(string tag);
    logic [31:0] e;
    e = 32'(mIdx);
    access(0, 12'h018, 2'd2, 32'h0, 1);
    check(busRdata == e, tag, "index readback", busRdata, e);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [11:0] offs [16];
  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; busSel = 0; busWrite = 0; busAddr = '0; busSize = '0;
    busWdata = '0; busSecure = 1;
    intStatIn = 1; intEnIn = 0;
    intInfo1In = 32'hA5C3_0F18; intInfo2In = 32'h0002_7E41;
    offs = '{12'h000, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h01C, 12'h01C,
             12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h004,
             12'hF00, 12'hFD0};

    // R1: reset state
    applyReset();
    access(0, 12'h000, 2'd2, 0, 1);
    readIdx("R1");

    // R5: wrap of the index on word reads, no step on narrow reads
    access(1, 12'h018, 2'd2, 32'(TW - 1), 1);
    access(1, 12'h01C, 2'd2, 32'hDEAD_BEEF, 1);
    readIdx("R5");
    access(0, 12'h01C, 2'd0, 0, 1);
    access(0, 12'h01C, 2'd1, 0, 1);
    readIdx("R5");
    for (int k = 0; k < TW + 1; k++) access(0, 12'h01C, 2'd2, 0, 1);
    readIdx("R5");
    // R3: index write modulo the table size
    access(1, 12'h018, 2'd2, 32'd13, 1);
    readIdx("R3");
    // R8: narrow merges into window and control, zero-fill elsewhere
    access(1, 12'h01C, 2'd0, 32'h0000_5A00, 1);
    access(1, 12'h01C, 2'd1, 32'h1234_0000, 1);
    access(1, 12'h000, 2'd0, 32'h0000_0010, 1);
    access(1, 12'h034, 2'd0, 32'h0000_0100, 1);
    access(1, 12'h024, 2'd2, 32'h0000_0001, 1);
    // R5: auto-increment off
    access(1, 12'h000, 2'd2, 32'h0, 1);
    access(0, 12'h01C, 2'd2, 0, 1);
    readIdx("R5");
    access(1, 12'h000, 2'd2, 32'h0000_0100, 1);
    // R7: non-secure attempts
    access(1, 12'h01C, 2'd2, 32'hFFFF_FFFF, 0);
    access(1, 12'h000, 2'd2, 32'h8000_0000, 0);
    access(0, 12'h010, 2'd2, 0, 0);
    access(0, 12'h01C, 2'd2, 0, 0);
    access(0, 12'hFD8, 2'd2, 0, 0);
    readIdx("R7");

    // mixed random traffic without lockdown
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [1:0]  sz;
      logic [31:0] wd;
      a  = offs[$urandom_range(0, 15)];
      if (a == 12'hFD0) a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
      sz = 2'($urandom_range(0, 2));
      if (sz == 2'd0) a[1:0] = 2'($urandom_range(0, 3));
      if (sz == 2'd1) a[1] = 1'($urandom_range(0, 1));
      wd = $urandom;
      if (a[11:2] == 10'd0) wd[31] = 1'b0;
      if (i % 50 == 0) intStatIn = ~intStatIn;
      access(1'($urandom_range(0, 1)), a, sz, wd, ($urandom_range(0, 9) != 0));
    end

    // R6: lockdown freezes control, window and enable
    access(1, 12'h000, 2'd2, 32'h8000_0110, 1);
    access(0, 12'h000, 2'd2, 0, 1);
    readIdx("R6");
    access(1, 12'h000, 2'd2, 32'h0, 1);
    access(0, 12'h000, 2'd2, 0, 1);
    access(1, 12'h01C, 2'd2, 32'h0BAD_F00D, 1);
    readIdx("R6");
    access(1, 12'h028, 2'd2, 32'h1, 1);
    access(1, 12'h018, 2'd2, 32'd2, 1);
    access(0, 12'h01C, 2'd2, 0, 1);
    readIdx("R6");
    // R6: only reset clears lockdown
    applyReset();
    access(0, 12'h000, 2'd2, 0, 1);
    access(1, 12'h028, 2'd2, 32'h1, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule